// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block sits beside a small 8-bit processor core. It decides which of 13 interrupt request lines the core services next. Software sets each source's enable bit, a master enable, and a two-bit priority level per source through a simple register write/read port. On every instruction boundary that the core signals, the block compares the pending, enabled requests. It picks the one with the highest level and breaks ties inside a level by a fixed source-index order, where the lower index wins. It presents that choice to the core as a one-cycle vector pulse.

An in-service record keeps track of the levels whose handlers are running. A new vector is issued only when its level is strictly above the highest running level. A handler at level 3 can therefore never be interrupted. A return pulse from the core retires the highest running level.

Sources 0 and 2 come from two external active-low pins. Each pin has a mode bit:
- In level mode the request follows the inverted pin.
- In edge mode a flag latches on a high-to-low pair of samples and clears when that source is vectored.

While the core sleeps, an enabled external request raises a wake output.

Top module: `irq_ctrl4`

## Requirements
- R1: After reset every register reads 0, `vec_valid_o` is 0 and `wake_o` is 0.
- R2: Register map, where bit k of a group stands for source k or source 7+k:
  - Address 0: bits 6:0 are the enables of sources 0..6, and bit 7 is the master enable.
  - Address 1: bits 5:0 are the enables of sources 7..12.
  - Addresses 2 and 3: the low and high priority bits of sources 0..6.
  - Addresses 4 and 5: the low and high priority bits of sources 7..12.
  - Address 6: bit 0 is the pin-0 mode and bit 1 is the pin-1 mode (1 = edge, 0 = level). Bits 2 and 3 read the pin-0 and pin-1 edge flags.
  - Reads are combinational.
- R3: A source takes part in arbitration only when both its enable bit and the master enable are 1.
- R4: When pending requests have different levels, the one with the highest level ({high bit, low bit}) is chosen, whatever its index.
- R5: Among pending requests of the same level, the lowest source index is chosen.
- R6: A vector is taken on a clock edge where `boundary_i` is 1 and a request qualifies. `vec_valid_o` is then 1 for exactly the following cycle, with `vec_id_o` and `vec_lvl_o` giving the source and its level.
- R7: While handlers are running, a request qualifies only if its level is strictly higher than the highest running level. Requests of equal or lower level wait.
- R8: While a level-3 handler is running, no vector is issued.
- R9: A `reti_i` pulse retires the highest running level, which restores the previous threshold. When no handler is running, every pending level qualifies.
- R10: In edge mode a pin's flag sets at the clock edge where the previous sample was 1 and the current sample is 0. The flag is the request. It clears when that source is vectored, and a pin that stays low does not set it again.
- R11: In level mode the external request equals the inverted pin, with no latching.
- R12: `src_req_i` bits 0 and 2 are ignored. Those sources come only from the pins.
- R13: `wake_o` is 1 exactly when `sleep_i` is 1 and an external request has its own enable bit set, whatever the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| src_req_i | input | 13 | Peripheral request lines, one per source index |
| ext_pin_i | input | 2 | External interrupt pins, active low |
| boundary_i | input | 1 | Instruction boundary, a vector may be taken |
| reti_i | input | 1 | Return from handler, retires the highest running level |
| sleep_i | input | 1 | Core is in idle or power-down |
| vec_valid_o | output | 1 | One-cycle vector pulse |
| vec_id_o | output | 4 | Vectored source index |
| vec_lvl_o | output | 2 | Level of the vectored source |
| wake_o | output | 1 | Wake request from an enabled external source |

## Verification
A vector appears one clock edge after the edge that samples `boundary_i`, and it is gone at the following edge. The bench drives the boundary pulse at a falling edge and queues the expected source and level. A monitor compares the queue entry at the next falling edge, and the bench confirms the pulse is cleared one cycle later. An edge flag becomes visible one edge after the edge that sampled the low pin, so the bench waits two falling edges before reading it back. Register reads and `wake_o` are combinational and are checked at the falling edge right after the inputs change.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_N  = 13;
  localparam int SPLIT  = 7;
  localparam int N_EXT  = 2;
  localparam int LVL_W  = 2;
  localparam int N_LVL  = 1 << LVL_W;
  localparam int ID_W   = $clog2(SRC_N);
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [ADDR_W-1:0] {
    ADR_EN_A  = 3'd0,
    ADR_EN_B  = 3'd1,
    ADR_PLO_A = 3'd2,
    ADR_PHI_A = 3'd3,
    ADR_PLO_B = 3'd4,
    ADR_PHI_B = 3'd5,
    ADR_EXT   = 3'd6
  } reg_adr_e;

  function automatic int ext_idx(input int pin);
    return (pin == 0) ? 0 : 2;
  endfunction
endpackage

// File: rtl/irq_ext_cond.sv
module irq_ext_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic ack_i,
  output logic req_o,
  output logic flag_o
);
  logic pin_q, flag_q, fall;

  assign fall = pin_q & ~pin_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pin_q <= pin_i;
      if (edge_mode_i && fall) flag_q <= 1'b1;
      else if (ack_i)          flag_q <= 1'b0;
    end
  end

  assign req_o  = edge_mode_i ? flag_q : ~pin_i;
  assign flag_o = flag_q;

  // R10
  flag_set_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(edge_mode_i && pin_q && !pin_i));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_pkg::*; #(
  parameter int N = SRC_N,
  parameter int IW = ID_W
) (
  input  logic [N-1:0]            pend_i,
  input  logic [N-1:0][LVL_W-1:0] lvl_i,
  input  logic                    svc_any_i,
  input  lvl_t                    svc_top_i,
  output logic                    valid_o,
  output logic [IW-1:0]           id_o,
  output lvl_t                    lvl_o
);
  logic any_pend;
  lvl_t best;

  always_comb begin
    any_pend = |pend_i;
    best = '0;
    for (int l = 0; l < N_LVL; l++)
      for (int k = 0; k < N; k++)
        if (pend_i[k] && lvl_i[k] == lvl_t'(l)) best = lvl_t'(l);
    id_o = '0;
    for (int k = N-1; k >= 0; k--)
      if (pend_i[k] && lvl_i[k] == best) id_o = IW'(k);
    lvl_o   = best;
    valid_o = any_pend && (!svc_any_i || best > svc_top_i);
  end

  // R5
  always_comb begin
    if (valid_o) win_pending_chk: assert (pend_i[id_o]);
  end
endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack import irq_pkg::*; (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic pop_i,
  output logic any_o,
  output lvl_t top_o
);
  logic [N_LVL-1:0] act_q, act_d;

  always_comb begin
    top_o = '0;
    for (int l = 0; l < N_LVL; l++)
      if (act_q[l]) top_o = lvl_t'(l);
    any_o = |act_q;
    act_d = act_q;
    if (pop_i && any_o) act_d[top_o] = 1'b0;
    if (push_i) act_d[push_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  // R7
  push_above_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!any_o || push_lvl_i > top_o));
  // R8
  top_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q[N_LVL-1] |-> !push_i);
  // R9
  pop_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && any_o && !push_i) |=> !act_q[$past(top_o)]);
endmodule

// File: rtl/irq_ctrl4.sv
module irq_ctrl4 import irq_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [SRC_N-1:0]  src_req_i,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic              boundary_i,
  input  logic              reti_i,
  input  logic              sleep_i,
  output logic              vec_valid_o,
  output logic [ID_W-1:0]   vec_id_o,
  output lvl_t              vec_lvl_o,
  output logic              wake_o
);
  localparam int HI_W = SRC_N - SPLIT;

  logic [SRC_N-1:0] en_q, plo_q, phi_q, req, pend;
  logic             gen_q;
  logic [N_EXT-1:0] mode_q, ext_req, ext_flag;
  logic [SRC_N-1:0][LVL_W-1:0] src_lvl;
  logic             win_valid, take, svc_any, ext_wake;
  logic [ID_W-1:0]  win_id;
  lvl_t             win_lvl, svc_top;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0; plo_q <= '0; phi_q <= '0; gen_q <= 1'b0; mode_q <= '0;
    end else if (reg_we_i) begin
      case (reg_adr_e'(reg_addr_i))
        ADR_EN_A: begin
          en_q[SPLIT-1:0] <= reg_wdata_i[SPLIT-1:0];
          gen_q           <= reg_wdata_i[DATA_W-1];
        end
        ADR_EN_B:  en_q[SRC_N-1:SPLIT]  <= reg_wdata_i[HI_W-1:0];
        ADR_PLO_A: plo_q[SPLIT-1:0]     <= reg_wdata_i[SPLIT-1:0];
        ADR_PHI_A: phi_q[SPLIT-1:0]     <= reg_wdata_i[SPLIT-1:0];
        ADR_PLO_B: plo_q[SRC_N-1:SPLIT] <= reg_wdata_i[HI_W-1:0];
        ADR_PHI_B: phi_q[SRC_N-1:SPLIT] <= reg_wdata_i[HI_W-1:0];
        ADR_EXT:   mode_q               <= reg_wdata_i[N_EXT-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_adr_e'(reg_addr_i))
      ADR_EN_A:  reg_rdata_o = {gen_q, en_q[SPLIT-1:0]};
      ADR_EN_B:  reg_rdata_o = DATA_W'(en_q[SRC_N-1:SPLIT]);
      ADR_PLO_A: reg_rdata_o = DATA_W'(plo_q[SPLIT-1:0]);
      ADR_PHI_A: reg_rdata_o = DATA_W'(phi_q[SPLIT-1:0]);
      ADR_PLO_B: reg_rdata_o = DATA_W'(plo_q[SRC_N-1:SPLIT]);
      ADR_PHI_B: reg_rdata_o = DATA_W'(phi_q[SRC_N-1:SPLIT]);
      ADR_EXT:   reg_rdata_o = DATA_W'({ext_flag, mode_q});
      default:   reg_rdata_o = '0;
    endcase
  end

  for (genvar g = 0; g < N_EXT; g++) begin : g_ext
    irq_ext_cond u_ext (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_i       (ext_pin_i[g]),
      .edge_mode_i (mode_q[g]),
      .ack_i       (take && (win_id == ID_W'(ext_idx(g)))),
      .req_o       (ext_req[g]),
      .flag_o      (ext_flag[g])
    );
  end

  for (genvar k = 0; k < SRC_N; k++) begin : g_lvl
    assign src_lvl[k] = {phi_q[k], plo_q[k]};
  end

  always_comb begin
    req      = src_req_i;
    ext_wake = 1'b0;
    for (int g = 0; g < N_EXT; g++) begin
      req[ext_idx(g)] = ext_req[g];
      ext_wake = ext_wake | (ext_req[g] & en_q[ext_idx(g)]);
    end
    pend = req & en_q & {SRC_N{gen_q}};
  end

  irq_arbiter u_arb (
    .pend_i    (pend),
    .lvl_i     (src_lvl),
    .svc_any_i (svc_any),
    .svc_top_i (svc_top),
    .valid_o   (win_valid),
    .id_o      (win_id),
    .lvl_o     (win_lvl)
  );

  assign take = boundary_i & win_valid;

  irq_svc_stack u_svc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (take),
    .push_lvl_i (win_lvl),
    .pop_i      (reti_i),
    .any_o      (svc_any),
    .top_o      (svc_top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0; vec_id_o <= '0; vec_lvl_o <= '0;
    end else begin
      vec_valid_o <= take;
      if (take) begin
        vec_id_o  <= win_id;
        vec_lvl_o <= win_lvl;
      end
    end
  end

  assign wake_o = sleep_i & ext_wake;

  // R6
  vec_after_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(boundary_i));
  // R3
  vec_needs_gen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> $past(gen_q));
  // R13
  wake_only_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> sleep_i);
endmodule

// File: tb/irq_ctrl4_test.sv
module irq_ctrl4_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [12:0] src_req = '0;
  logic [1:0] ext_pin = 2'b11;
  logic boundary = 1'b0, reti = 1'b0, sleep = 1'b0;
  logic vec_valid, wake;
  logic [3:0] vec_id;
  logic [1:0] vec_lvl;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [3:0] q_id[$];
  logic [1:0] q_lvl[$];
  string      q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl4 uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .src_req_i(src_req),
    .ext_pin_i(ext_pin), .boundary_i(boundary), .reti_i(reti), .sleep_i(sleep),
    .vec_valid_o(vec_valid), .vec_id_o(vec_id), .vec_lvl_o(vec_lvl), .wake_o(wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // monitor: scoreboard pop on each vector pulse
  always @(negedge clk) begin
    if (rst_ni && vec_valid) begin
      if (q_id.size() == 0) chk("R6 unexpected vector", 1, 0);
      else begin
        automatic string t = q_tag.pop_front();
        chk({t, " id"}, int'(vec_id), int'(q_id.pop_front()));
        chk({t, " lvl"}, int'(vec_lvl), int'(q_lvl.pop_front()));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      chk("watchdog", 1, 0);
      summary();
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_addr = a;
    #1 chk(tag, int'(reg_rdata), int'(exp));
  endtask

  // driver: boundary pulse, expected vector into the queue
  task automatic take(input bit exp_v, input logic [3:0] id, input logic [1:0] lvl,
                      input string tag);
    @(negedge clk); boundary = 1'b1;
    if (exp_v) begin q_id.push_back(id); q_lvl.push_back(lvl); q_tag.push_back(tag); end
    @(negedge clk); boundary = 1'b0;
    if (!exp_v) chk({tag, " no vector"}, int'(vec_valid), 0);
    @(negedge clk); chk("R6 single-cycle pulse", int'(vec_valid), 0);
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    for (int a = 0; a < 7; a++) rd(3'(a), 8'h00, "R1 reset reg");
    chk("R1 reset vec", int'(vec_valid), 0);
    chk("R1 reset wake", int'(wake), 0);

    wr(0, 8'h2F); wr(1, 8'h34);
    rd(0, 8'h2F, "R2 en_a"); rd(1, 8'h34, "R2 en_b");
    wr(3, 8'h41); rd(3, 8'h41, "R2 phi_a"); wr(3, 8'h00);
    src_req = 13'b0_0000_0000_1010;
    take(0, 0, 0, "R3 master off");
    wr(0, 8'hAF);
    take(1, 4'd1, 2'd0, "R5 lowest index wins");
    take(0, 0, 0, "R7 equal level waits");
    wr(5, 8'h04); src_req[9] = 1'b1;
    take(1, 4'd9, 2'd2, "R7 higher preempts");
    wr(2, 8'h20); src_req[5] = 1'b1;
    take(0, 0, 0, "R7 lower waits");
    src_req = 13'b0_0000_0010_1000;
    do_reti();
    take(1, 4'd5, 2'd1, "R4 level over index R9");
    do_reti(); do_reti();
    src_req = '0;
    wr(4, 8'h30); wr(5, 8'h34);
    src_req[12] = 1'b1;
    take(1, 4'd12, 2'd3, "R4 level 3");
    src_req[11] = 1'b1;
    take(0, 0, 0, "R8 top level locked");
    do_reti();
    take(1, 4'd11, 2'd3, "R9 R5 after return");
    do_reti();
    src_req = '0;

    wr(6, 8'h01); rd(6, 8'h01, "R2 mode");
    src_req[0] = 1'b1; src_req[2] = 1'b1;
    take(0, 0, 0, "R12 ignored lines");
    src_req = '0;
    @(negedge clk); ext_pin[0] = 1'b0;
    @(negedge clk); @(negedge clk);
    rd(6, 8'h05, "R10 flag set");
    take(1, 4'd0, 2'd0, "R10 edge vector");
    rd(6, 8'h01, "R10 flag cleared");
    do_reti();
    take(0, 0, 0, "R10 no retrigger");
    ext_pin[0] = 1'b1;

    @(negedge clk); ext_pin[1] = 1'b0;
    take(1, 4'd2, 2'd0, "R11 level vector");
    do_reti();
    take(1, 4'd2, 2'd0, "R11 follows pin");
    do_reti();
    @(negedge clk); ext_pin[1] = 1'b1;
    take(0, 0, 0, "R11 pin released");

    @(negedge clk); ext_pin[1] = 1'b0; sleep = 1'b1;
    #1 chk("R13 wake set", int'(wake), 1);
    wr(0, 8'hAB);
    #1 chk("R13 wake needs enable", int'(wake), 0);
    wr(0, 8'h2F);
    #1 chk("R13 wake without master", int'(wake), 1);
    @(negedge clk); sleep = 1'b0;
    #1 chk("R13 awake", int'(wake), 0);
    ext_pin[1] = 1'b1;

    repeat (3) @(negedge clk);
    chk("R6 queue drained", q_id.size(), 0);
    summary();
  end
endmodule